// File: doc/BRIEF.md
# Interrupt Status and Mask Aggregator

This block gathers single-cycle event pulses from a bus controller's datapath into a 10-bit sticky status register. It holds a 10-bit mask register that direct writes cannot change. Software moves mask bits only through two write-only locations: one unmasks the positions written as 1, the other masks them. A single level interrupt line is raised whenever a status bit is set while its mask bit is clear.

Software reaches the block through a plain register port. A 2-bit address selects one of four locations, a write strobe is qualified by that address, and the read data is a combinational view of the addressed location. The datapath side has no handshake: each event input is sampled on every clock edge. There is no data stream crossing the block, so nothing here needs valid/ready and there is no back-pressure to manage.

Status position 8 is special. It is a live copy of its source input and software can neither set nor clear it. All other positions are sticky and are cleared by writing 1. When an event and a software clear hit the same bit in one cycle, the event wins, so no event is lost.

Top module: `irq_ctrl_top`

## Requirements
- R1: After reset the status location (address 0) reads 0x000, the mask location (address 1) reads 0x2FF and `irq_o` is low.
- R2: A high level on `evt_i[b]` at a clock edge, for any b other than 8, sets status bit b at that edge. The bit stays set after the event input returns low.
- R3: Writing address 0 clears every status bit from the set 0x2FF whose write-data bit is 1. Status bits written as 0 keep their value.
- R4: Status bit 8 takes the value of `evt_i[8]` at each clock edge. Writes to address 0 have no effect on it.
- R5: If an event and a write-1 clear reach the same status bit at the same edge, the bit ends up set.
- R6: Writing address 1 leaves the mask unchanged.
- R7: Writing address 2 clears the mask bits at the positions where the write data is 1. Other mask bits are unchanged.
- R8: Writing address 3 sets the mask bits at the positions where the write data is 1. Other mask bits are unchanged.
- R9: Reads of address 2 and address 3 return zero.
- R10: `irq_o` is a registered output. After every clock edge it equals the OR of (status AND NOT mask) as held after that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | 10 | Event pulses from the datapath; bit 8 is a level source |
| reg_addr_i | input | 2 | Register select: 0 status, 1 mask, 2 enable, 3 disable |
| reg_wr_i | input | 1 | Write strobe for the selected register |
| reg_wdata_i | input | 10 | Write data |
| reg_rdata_o | output | 10 | Read data of the selected register |
| irq_o | output | 1 | Level interrupt request |

## Verification
The bench drives an event and a write-1 clear into the same status bit in one cycle. A design that lets the clear win would read back zero there and drop the event. It writes address 0 with bit 8 set while the bit 8 source is high: if that bit were treated as sticky or clearable, the read-back and the interrupt would go wrong, first while the source is held high and again after it drops. It also writes the mask location directly and confirms that the mask did not move. It checks that the enable and disable locations read as zero and that they clear or set only the bits written as 1. After every such step it compares `irq_o` against a model, which catches a design that reads the mask with inverted sense or that lags one cycle behind.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  localparam int unsigned IRQ_W  = 10;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_STATUS  = 2'd0,
    SEL_MASK    = 2'd1,
    SEL_UNMASK  = 2'd2,
    SEL_MASKSET = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned N = 10,
  parameter logic [N-1:0] RO_BITS = 'h100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic [N-1:0] sw_clr,
  output logic [N-1:0] stat_q,
  output logic [N-1:0] stat_d
);
  localparam logic [N-1:0] STICKY = ~RO_BITS;

  // sticky bits: event has priority over the software clear
  // live bits: straight copy of the source
  always_comb begin
    stat_d = (evt & RO_BITS) | (STICKY & (evt | (stat_q & ~sw_clr)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned N = 10,
  parameter logic [N-1:0] RST_VAL = 'h2FF
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         unmask_wr,
  input  logic         maskset_wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask_q,
  output logic [N-1:0] mask_d
);
  always_comb begin
    mask_d = mask_q;
    if (unmask_wr)  mask_d = mask_d & ~wdata;
    if (maskset_wr) mask_d = mask_d | wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= RST_VAL;
    else        mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_aggregate.sv
module irq_aggregate #(
  parameter int unsigned N = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] stat_d,
  input  logic [N-1:0] mask_d,
  output logic         irq_q
);
  logic pend;

  always_comb pend = |(stat_d & ~mask_d);

  // computed from next-state values so the line moves with the registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pend;
  end
endmodule

// File: rtl/irq_ctrl_top.sv
module irq_ctrl_top
  import irq_ctrl_pkg::*;
#(
  parameter int unsigned N_SRC = IRQ_W,
  parameter logic [N_SRC-1:0] RO_BITS  = 'h100,
  parameter logic [N_SRC-1:0] MASK_RST = 'h2FF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_wr_i,
  input  logic [N_SRC-1:0]  reg_wdata_i,
  output logic [N_SRC-1:0]  reg_rdata_o,
  output logic              irq_o
);
  reg_sel_e         sel;
  logic             wr_status, wr_unmask, wr_maskset;
  logic [N_SRC-1:0] clr_vec;
  logic [N_SRC-1:0] stat_q, stat_d, mask_q, mask_d;

  always_comb begin
    sel        = reg_sel_e'(reg_addr_i);
    wr_status  = reg_wr_i && (sel == SEL_STATUS);
    wr_unmask  = reg_wr_i && (sel == SEL_UNMASK);
    wr_maskset = reg_wr_i && (sel == SEL_MASKSET);
    clr_vec    = wr_status ? reg_wdata_i : '0;
  end

  irq_status_reg #(.N(N_SRC), .RO_BITS(RO_BITS)) u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt_i), .sw_clr(clr_vec),
    .stat_q(stat_q), .stat_d(stat_d)
  );

  irq_mask_reg #(.N(N_SRC), .RST_VAL(MASK_RST)) u_mask (
    .clk(clk), .rst_n(rst_n), .unmask_wr(wr_unmask), .maskset_wr(wr_maskset),
    .wdata(reg_wdata_i), .mask_q(mask_q), .mask_d(mask_d)
  );

  irq_aggregate #(.N(N_SRC)) u_agg (
    .clk(clk), .rst_n(rst_n), .stat_d(stat_d), .mask_d(mask_d), .irq_q(irq_o)
  );

  always_comb begin
    case (sel)
      SEL_STATUS: reg_rdata_o = stat_q;
      SEL_MASK:   reg_rdata_o = mask_q;
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_ctrl_sva.sv
module irq_ctrl_sva #(
  parameter int unsigned N = 10,
  parameter logic [N-1:0] RO_BITS = 'h100
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] evt_i,
  input logic [1:0]   reg_addr_i,
  input logic         reg_wr_i,
  input logic [N-1:0] reg_wdata_i,
  input logic [N-1:0] reg_rdata_o,
  input logic         irq_o,
  input logic [N-1:0] status,
  input logic [N-1:0] mask
);
  localparam logic [N-1:0] STICKY = ~RO_BITS;

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|(evt_i & STICKY)) |=> ((status & $past(evt_i & STICKY)) == $past(evt_i & STICKY)));

  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i == 2'd0) |=>
      ((status & $past(status) & STICKY) == ($past(status) & STICKY)));

  p_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd0) |=>
      ((status & $past(reg_wdata_i & ~evt_i & STICKY)) == '0));

  p_live_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status & RO_BITS) == $past(evt_i & RO_BITS)));

  p_mask_ro_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_i && reg_addr_i[1]) |=> $stable(mask));

  p_unmask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd2) |=> ((mask & $past(reg_wdata_i)) == '0));

  p_maskset_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == 2'd3) |=> ((mask & $past(reg_wdata_i)) == $past(reg_wdata_i)));

  p_zero_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr_i[1] |-> (reg_rdata_o == '0));

  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (|(status & ~mask)));
endmodule

bind irq_ctrl_top irq_ctrl_sva #(.N(N_SRC), .RO_BITS(RO_BITS)) u_sva (
  .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr_i(reg_addr_i),
  .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
  .irq_o(irq_o), .status(stat_q), .mask(mask_q)
);

// File: tb/irq_ctrl_top_test.sv
module irq_ctrl_top_test;
  localparam logic [9:0] STICKY = 10'h2FF;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] evt_i = '0;
  logic [1:0] reg_addr_i = '0;
  logic       reg_wr_i = 1'b0;
  logic [9:0] reg_wdata_i = '0;
  logic [9:0] reg_rdata_o;
  logic       irq_o;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [9:0] m_stat = '0;
  logic [9:0] m_mask = 10'h2FF;
  logic       lvl8 = 1'b0;

  logic [9:0] qd[$];
  logic       qi[$];
  string      qt[$];

  always #4 clk = ~clk;

  irq_ctrl_top uut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .reg_addr_i(reg_addr_i),
    .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .irq_o(irq_o)
  );

  function automatic logic m_irq();
    return |(m_stat & ~m_mask);
  endfunction

  // driver: queue a read of one location and the level expected on irq_o
  task automatic rd(input logic [1:0] a, input string tag);
    @(negedge clk);
    reg_addr_i = a;
    reg_wr_i   = 1'b0;
    m_stat[8]  = lvl8;
    case (a)
      2'd0:    qd.push_back(m_stat);
      2'd1:    qd.push_back(m_mask);
      default: qd.push_back(10'h000);
    endcase
    qi.push_back(m_irq());
    qt.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [9:0] d);
    @(negedge clk);
    reg_addr_i = a; reg_wdata_i = d; reg_wr_i = 1'b1;
    case (a)
      2'd0:    m_stat = m_stat & ~(d & STICKY);
      2'd2:    m_mask = m_mask & ~d;
      2'd3:    m_mask = m_mask | d;
      default: ;
    endcase
    m_stat[8] = lvl8;
    @(negedge clk);
    reg_wr_i = 1'b0;
    m_stat[8] = lvl8;
  endtask

  task automatic pulse(input logic [9:0] e);
    @(negedge clk);
    evt_i = (e & STICKY) | (10'(lvl8) << 8);
    m_stat = m_stat | (e & STICKY);
    m_stat[8] = lvl8;
    @(negedge clk);
    evt_i = 10'(lvl8) << 8;
  endtask

  task automatic pulse_and_clear(input logic [9:0] e, input logic [9:0] c);
    @(negedge clk);
    evt_i = (e & STICKY) | (10'(lvl8) << 8);
    reg_addr_i = 2'd0; reg_wdata_i = c; reg_wr_i = 1'b1;
    m_stat = (m_stat & ~(c & STICKY)) | (e & STICKY);
    m_stat[8] = lvl8;
    @(negedge clk);
    evt_i = 10'(lvl8) << 8;
    reg_wr_i = 1'b0;
  endtask

  task automatic set_lvl8(input logic v);
    @(negedge clk);
    lvl8 = v;
    evt_i[8] = v;
  endtask

  // monitor: compares queued expectations away from the clock edge
  initial begin
    forever begin
      logic [9:0] ed;
      logic       ei;
      string      et;
      @(posedge clk);
      #2;
      if (qd.size() > 0) begin
        ed = qd.pop_front();
        ei = qi.pop_front();
        et = qt.pop_front();
        tests++;
        if (reg_rdata_o !== ed || irq_o !== ei) begin
          fails++;
          $display("FAIL %s: rdata=%h irq=%b expected rdata=%h irq=%b",
                   et, reg_rdata_o, irq_o, ed, ei);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, "R1 status reset");
    rd(2'd1, "R1 mask reset");
    pulse(10'h001);
    rd(2'd0, "R2 event sets bit0");
    rd(2'd0, "R2 bit0 stays set");
    wr(2'd2, 10'h001);
    rd(2'd1, "R7 unmask bit0");
    rd(2'd0, "R10 irq with unmasked status");
    rd(2'd2, "R9 enable location reads zero");
    rd(2'd3, "R9 disable location reads zero");
    wr(2'd0, 10'h001);
    rd(2'd0, "R3 write-1 clear bit0");
    pulse(10'h0A5);
    wr(2'd0, 10'h005);
    rd(2'd0, "R3 partial clear");
    wr(2'd1, 10'h000);
    rd(2'd1, "R6 direct mask write ignored");
    wr(2'd2, 10'h0A0);
    rd(2'd0, "R10 irq after unmask of pending");
    wr(2'd3, 10'h0A1);
    rd(2'd1, "R8 mask set");
    rd(2'd0, "R10 irq drops after remask");
    pulse_and_clear(10'h008, 10'h008);
    rd(2'd0, "R5 event beats clear");
    set_lvl8(1'b1);
    rd(2'd0, "R4 bit8 follows source, irq R10");
    wr(2'd0, 10'h100);
    rd(2'd0, "R4 bit8 not cleared by write");
    set_lvl8(1'b0);
    rd(2'd0, "R4 bit8 drops with source");
    pulse(10'h200);
    wr(2'd2, 10'h200);
    rd(2'd0, "R2 bit9 sets and R10 irq");
    wr(2'd0, 10'h2FF);
    rd(2'd0, "R3 clear all sticky");
    wr(2'd2, 10'h3FF);
    rd(2'd1, "R7 unmask all");
    pulse(10'h080);
    rd(2'd0, "R10 irq from bit7");
    wr(2'd3, 10'h3FF);
    rd(2'd0, "R8 mask all drops irq");
    while (qd.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule